// File: doc/BRIEF.md
# Reconfigurable Shift-Add Complex Cross-Correlator

This block slides a stream of complex received samples past a known reference sequence and produces, for every accepted sample, the complex correlation of the reference with the most recent samples. It has no hardware multipliers. Two shared shift-add banks turn the current input sample into eight scaled copies of its real part and eight of its imaginary part, in steps of one eighth. Every tap of a transposed delay line then uses a small per-tap code to pick one copy from each bank, negates or zeroes it, and adds the result to the partial sum that the previous tap registered.

The per-tap codes sit in a register file. Software writes it while the correlator is disabled, so one instance can serve several reference sequences. A run-time tap selector picks which partial sum drives the output, and this sets the correlation length anywhere from 1 up to the design-time tap count. Typical settings are 64 or 128 samples. Samples come in on a valid/ready stream and results leave on a valid/ready stream with a one-entry output stage. The input is ready only while the correlator is enabled and the output stage is empty or being drained in the same cycle, so back-pressure on the output stalls the whole delay line.

Top module: `xcorr_mless`

## Requirements
- R1: With L = tap_sel+1, each result is the sum over k = 0..L-1 of the product of coefficient slot k with the sample accepted L-1-k samples before the current one. Samples accepted before the last reset count as zero. Coefficient slot TAPS-1 therefore meets the newest sample when L = TAPS.
- R2: A coefficient word is 10 bits. Bits 9:5 code the real part P_re and bits 4:0 code the imaginary part P_im. In each 5-bit code, bit 4 = zero flag (value 0), bit 3 = negate, and bits 2:0 = m, which gives magnitude (m+1)/8. A scaled term is floor(x*(m+1)/8), negated when bit 3 is set. The real result adds term(in_re,P_re) and term(in_im,P_im). The imaginary result is term(in_im,P_re) minus term(in_re,P_im). This is the product with the conjugated coefficient.
- R3: When wr_en is high, wr_data goes into coefficient slot wr_addr, but only while en is low. A write offered while en is high is dropped and changes no later result.
- R4: in_ready is high exactly when en is high and either out_valid is low or out_ready is high. A sample is taken only on a cycle where in_valid and in_ready are both high.
- R5: out_valid rises in the cycle after a sample is taken. It stays high, and out_re/out_im stay constant for a fixed tap_sel, until a cycle with out_ready high.
- R6: Partial sums and outputs are 21-bit two's complement values with 15 fraction bits. When they overflow they wrap modulo 2^21 and do not saturate.
- R7: A synchronous reset clears every partial sum to zero and out_valid to low, and it sets every coefficient slot to the zero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Correlator enable; coefficient writes only when low |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | TAP_W | Coefficient slot index |
| wr_data | input | 10 | Coefficient word (real code 9:5, imaginary code 4:0) |
| tap_sel | input | TAP_W | Output tap index; correlation length is tap_sel+1 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_re | input | 16 | Input real part, signed Q1.15 |
| in_im | input | 16 | Input imaginary part, signed Q1.15 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_re | output | 21 | Result real part, signed Q6.15 |
| out_im | output | 21 | Result imaginary part, signed Q6.15 |

## Verification
The case that needs care is the cycle in which a new sample is taken while the pending result is handed off. Long runs are sent back to back with out_ready held high, so every take also pops the previous result. Each result is compared with a direct-form sum computed in the bench over its own sample history, which shows that no sample is dropped or used twice. A separate run holds out_ready low while a sample is offered and confirms that the sample is refused, the held result stays unchanged, and later results still match the unchanged history.

// File: rtl/xcm_pkg.sv
package xcm_pkg;
  localparam int IN_W   = 16;
  localparam int ACC_W  = 21;
  localparam int MAG_W  = 3;
  localparam int NLVL   = 1 << MAG_W;
  localparam int SC_W   = IN_W + 1;

  typedef struct packed {
    logic             zero;
    logic             neg;
    logic [MAG_W-1:0] mag;
  } ccode_t;

  typedef struct packed {
    ccode_t re;
    ccode_t im;
  } cword_t;

  localparam int CW_W = $bits(cword_t);

  typedef logic [NLVL-1:0][SC_W-1:0] bank_t;

  localparam cword_t CW_ZERO = cword_t'({1'b1, 1'b0, {MAG_W{1'b0}},
                                         1'b1, 1'b0, {MAG_W{1'b0}}});
endpackage

// File: rtl/xcm_scaler.sv
module xcm_scaler
  import xcm_pkg::*;
(
  input  logic signed [IN_W-1:0] v,
  output bank_t                  bank
);
  localparam int PW = IN_W + MAG_W;

  for (genvar m = 0; m < NLVL; m++) begin : g_lvl
    logic signed [PW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int b = 0; b <= MAG_W; b++) begin
        if ((((m + 1) >> b) & 1) != 0) acc = acc + (PW'(v) <<< b);
      end
    end
    // floor divide by 2^MAG_W, one guard bit so negation cannot overflow
    assign bank[m] = {acc[PW-1], acc[PW-1:MAG_W]};
  end
endmodule

// File: rtl/xcm_tap.sv
module xcm_tap
  import xcm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  cword_t                  code,
  input  bank_t                   xr_bank,
  input  bank_t                   xi_bank,
  input  logic signed [ACC_W-1:0] prev_re,
  input  logic signed [ACC_W-1:0] prev_im,
  output logic signed [ACC_W-1:0] sum_re,
  output logic signed [ACC_W-1:0] sum_im
);
  function automatic logic signed [ACC_W-1:0] pick(input bank_t bank, input ccode_t c);
    logic signed [SC_W-1:0]  s;
    logic signed [ACC_W-1:0] e;
    s = $signed(bank[c.mag]);
    e = {{(ACC_W-SC_W){s[SC_W-1]}}, s};
    if (c.zero) return '0;
    return c.neg ? -e : e;
  endfunction

  logic signed [ACC_W-1:0] term_re, term_im;

  always_comb begin
    term_re = pick(xr_bank, code.re) + pick(xi_bank, code.im);
    term_im = pick(xi_bank, code.re) - pick(xr_bank, code.im);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_re <= '0;
      sum_im <= '0;
    end else if (adv) begin
      sum_re <= prev_re + term_re;
      sum_im <= prev_im + term_im;
    end
  end
endmodule

// File: rtl/xcorr_mless.sv
module xcorr_mless
  import xcm_pkg::*;
#(
  parameter int TAPS  = 128,
  parameter int TAP_W = $clog2(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    wr_en,
  input  logic [TAP_W-1:0]        wr_addr,
  input  logic [CW_W-1:0]         wr_data,
  input  logic [TAP_W-1:0]        tap_sel,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_re,
  input  logic signed [IN_W-1:0]  in_im,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [ACC_W-1:0] out_re,
  output logic signed [ACC_W-1:0] out_im
);
  cword_t [TAPS-1:0] coef_q;
  bank_t             xr_bank, xi_bank;
  logic              take;
  logic signed [ACC_W-1:0] s_re [TAPS];
  logic signed [ACC_W-1:0] s_im [TAPS];

  // coefficient register file, writable only while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) coef_q[k] <= CW_ZERO;
    end else if (wr_en && !en) begin
      coef_q[wr_addr] <= cword_t'(wr_data);
    end
  end

  // stream handshake with a one-entry output stage
  assign in_ready = en && (!out_valid || out_ready);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)            out_valid <= 1'b0;
    else if (take)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  // shared scaled copies of the current sample
  xcm_scaler u_scl_re (.v(in_re), .bank(xr_bank));
  xcm_scaler u_scl_im (.v(in_im), .bank(xi_bank));

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [ACC_W-1:0] p_re, p_im;
    if (k == 0) begin : g_head
      assign p_re = '0;
      assign p_im = '0;
    end else begin : g_body
      assign p_re = s_re[k-1];
      assign p_im = s_im[k-1];
    end
    xcm_tap u_tap (
      .clk    (clk),
      .rst    (rst),
      .adv    (take),
      .code   (coef_q[k]),
      .xr_bank(xr_bank),
      .xi_bank(xi_bank),
      .prev_re(p_re),
      .prev_im(p_im),
      .sum_re (s_re[k]),
      .sum_im (s_im[k])
    );
  end

  assign out_re = s_re[tap_sel];
  assign out_im = s_im[tap_sel];
endmodule

// File: rtl/xcm_checker.sv
module xcm_checker
  import xcm_pkg::*;
#(
  parameter int TAPS  = 128,
  parameter int TAP_W = $clog2(TAPS)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic                    wr_en,
  input logic [TAP_W-1:0]        tap_sel,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [ACC_W-1:0] out_re,
  input logic signed [ACC_W-1:0] out_im,
  input logic [TAPS*CW_W-1:0]    coef_flat
);
  assert_idle_not_ready_R4: assert property (@(posedge clk) disable iff (rst)
    !en |-> !in_ready);

  assert_valid_after_take_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_while_stalled_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && (!$stable(tap_sel) || ($stable(out_re) && $stable(out_im)))));

  assert_coef_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (en || !wr_en) |=> $stable(coef_flat));

  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && out_re == '0 && out_im == '0));
endmodule

bind xcorr_mless xcm_checker #(.TAPS(TAPS), .TAP_W(TAP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .wr_en    (wr_en),
  .tap_sel  (tap_sel),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_re   (out_re),
  .out_im   (out_im),
  .coef_flat(coef_q)
);

// File: tb/sim_xcorr_mless.sv
module sim_xcorr_mless;
  localparam int TAPS  = 128;
  localparam int TAP_W = 7;

  logic clk = 1'b0;
  logic rst, en, wr_en, in_valid, out_ready;
  logic [TAP_W-1:0] wr_addr, tap_sel;
  logic [9:0] wr_data;
  logic signed [15:0] in_re, in_im;
  logic in_ready, out_valid;
  logic signed [20:0] out_re, out_im;

  xcorr_mless #(.TAPS(TAPS), .TAP_W(TAP_W)) u0 (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tap_sel(tap_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im));

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [31:0] rng = 32'h1234_5678;
  logic [4:0] cm_re [TAPS];
  logic [4:0] cm_im [TAPS];
  int hist_r [TAPS];
  int hist_i [TAPS];
  logic [20:0] exp_r, exp_i;

  task automatic check(input string req, input bit ok, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  function automatic int sc(input int v, input logic [4:0] c);
    int t;
    if (c[4]) return 0;
    t = (v * (int'(c[2:0]) + 1)) >>> 3;
    return c[3] ? -t : t;
  endfunction

  function automatic void clear_hist();
    for (int k = 0; k < TAPS; k++) begin
      hist_r[k] = 0;
      hist_i[k] = 0;
    end
  endfunction

  function automatic void push_hist(input int xr, input int xi);
    for (int k = TAPS - 1; k > 0; k--) begin
      hist_r[k] = hist_r[k-1];
      hist_i[k] = hist_i[k-1];
    end
    hist_r[0] = xr;
    hist_i[0] = xi;
  endfunction

  function automatic void calc(input int len);
    int ar, ai, d;
    ar = 0;
    ai = 0;
    for (int k = 0; k < len; k++) begin
      d  = len - 1 - k;
      ar = ar + sc(hist_r[d], cm_re[k]) + sc(hist_i[d], cm_im[k]);
      ai = ai + sc(hist_i[d], cm_re[k]) - sc(hist_r[d], cm_im[k]);
    end
    exp_r = ar[20:0];
    exp_i = ai[20:0];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    clear_hist();
    for (int k = 0; k < TAPS; k++) begin
      cm_re[k] = 5'b10000;
      cm_im[k] = 5'b10000;
    end
  endtask

  // mode 0: pattern from seed, mode 1: all +1.0 real / zero imaginary
  task automatic load_coefs(input int seed, input int mode);
    en = 1'b0;
    for (int k = 0; k < TAPS; k++) begin
      @(negedge clk);
      if (mode == 1) begin
        cm_re[k] = 5'b00111;
        cm_im[k] = 5'b10000;
      end else begin
        cm_re[k] = {((k * seed) % 7) == 3, 1'(k ^ seed), 3'((k * 3 + seed) % 8)};
        cm_im[k] = {((k + seed) % 9) == 4, 1'((k >> 1) ^ seed), 3'((k * 5 + seed) % 8)};
      end
      wr_en   = 1'b1;
      wr_addr = TAP_W'(k);
      wr_data = {cm_re[k], cm_im[k]};
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mode 0: random, 1: zeros, 2: full-scale constant
  task automatic run_stream(input int n, input int tsel, input string req,
                            input int mode, input bit do_chk);
    int xr, xi;
    logic [31:0] r;
    tap_sel   = TAP_W'(tsel);
    en        = 1'b1;
    out_ready = 1'b1;
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      if (s > 0 && do_chk)
        check(req, out_valid === 1'b1 && out_re === exp_r && out_im === exp_i,
              {out_re, out_im}, {exp_r, exp_i});
      r  = next_rng();
      xr = (mode == 0) ? int'($signed(r[15:0])) : (mode == 2) ? 32767 : 0;
      xi = (mode == 0) ? int'($signed(r[31:16])) : (mode == 2) ? -32768 : 0;
      push_hist(xr, xi);
      calc(tsel + 1);
      in_valid = 1'b1;
      in_re    = 16'(xr);
      in_im    = 16'(xi);
    end
    @(negedge clk);
    if (do_chk)
      check(req, out_valid === 1'b1 && out_re === exp_r && out_im === exp_i,
            {out_re, out_im}, {exp_r, exp_i});
    in_valid = 1'b0;
  endtask

  task automatic flush();
    run_stream(TAPS + 2, TAPS - 1, "flush", 1, 1'b0);
    clear_hist();
  endtask

  task automatic t_reset_state();
    en = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R7 out_valid after reset", out_valid === 1'b0, out_valid, 0);
    check("R7 sums cleared", out_re === 21'd0 && out_im === 21'd0, {out_re, out_im}, 0);
    check("R4 not ready while disabled", in_ready === 1'b0, in_ready, 0);
    @(negedge clk);
    check("R4 no take while disabled", out_valid === 1'b0, out_valid, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_short_len();
    load_coefs(5, 0);
    run_stream(90, 63, "R1 R2 length 64", 0, 1'b1);
  endtask

  task automatic t_long_len();
    flush();
    load_coefs(11, 0);
    run_stream(150, 127, "R1 R2 length 128", 0, 1'b1);
    run_stream(20, 31, "R1 length 32", 0, 1'b1);
  endtask

  task automatic t_write_locked();
    en = 1'b1;
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = TAP_W'(TAPS - 1);
    wr_data = ~{cm_re[TAPS-1], cm_im[TAPS-1]};
    @(negedge clk);
    wr_en = 1'b0;
    run_stream(12, 127, "R3 write while enabled dropped", 0, 1'b1);
  endtask

  task automatic t_backpressure();
    logic [20:0] hr, hi;
    run_stream(1, 127, "R5 pre-stall", 0, 1'b1);
    out_ready = 1'b0;
    @(negedge clk);
    // out_valid still 1 from the last sample; present a sample that must be refused
    hr = out_re;
    hi = out_im;
    in_valid = 1'b1;
    in_re = 16'sh1111;
    in_im = -16'sh2222;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R4 refused while output stalled", in_ready === 1'b0, in_ready, 0);
      check("R5 result held", out_valid === 1'b1 && out_re === hr && out_im === hi,
            {out_re, out_im}, {hr, hi});
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R5 drained", out_valid === 1'b0, out_valid, 0);
    run_stream(10, 127, "R5 history intact after stall", 0, 1'b1);
  endtask

  task automatic t_wrap();
    flush();
    load_coefs(0, 1);
    run_stream(140, 127, "R6 wrap modulo 2^21", 2, 1'b1);
  endtask

  task automatic t_reset_mid();
    do_reset();
    run_stream(6, 127, "R7 coefficients and sums cleared", 0, 1'b1);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tap_sel = '0; in_valid = 1'b0; in_re = '0; in_im = '0; out_ready = 1'b1;
    do_reset();
    t_reset_state();
    t_short_len();
    t_long_len();
    t_write_locked();
    t_backpressure();
    t_wrap();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule